// File: doc/BRIEF.md
# Packed Element Permute Unit

This block rearranges the elements of a 128-bit vector, or of a 64-bit vector held in the low half of the operand buses. It covers the common data-movement primitives of a packed SIMD datapath. It has immediate-controlled four-lane selection from one source or from two sources. It merges the low or high halves of two operands element by element at 8, 16, 32 or 64-bit granularity. It permutes the words of one 64-bit half while the other half passes through. It also performs a byte table lookup in which a second vector supplies a per-byte index and a per-byte clear flag.

Each request arrives as a single beat on a valid/ready input stream. The beat carries an operation code, an element size, a half-width flag, an 8-bit immediate and two operands. The result leaves one cycle later on a valid/ready output stream. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high, and delivered on an edge where `out_valid` and `out_ready` are both high. The unit holds a single result register. `in_ready` is high when that register is empty or is being emptied in the same cycle, so back-pressure from the consumer reaches the producer with no added cycle. While the consumer stalls, the held result does not change.

Operation codes on `in_op`: 0 one-source shuffle, 1 two-source select, 2 low-half merge, 3 high-half merge, 4 upper-word shuffle, 5 lower-word shuffle, 6 byte lookup, 7 reserved. Element size codes on `in_size`: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Lane k of a vector occupies bits [w*k+w-1 : w*k] for lane width w.

Top module: `perm_unit`

## Requirements
- R1: Op 0. With in_half=0, 32-bit result lane k (k=0..3) is lane in_imm[2k+1:2k] of a. With in_half=1, 16-bit result lane k is 16-bit lane in_imm[2k+1:2k] of a[63:0].
- R2: Op 1 with in_size other than 3 works on 32-bit lanes. Result lanes 0 and 1 take lane in_imm[1:0] and lane in_imm[3:2] of a. Result lanes 2 and 3 take lane in_imm[5:4] and lane in_imm[7:6] of b.
- R3: Op 1 with in_size=3 works on 64-bit halves. Result bits 63:0 are a[127:64] when in_imm[0]=1, else a[63:0]. Result bits 127:64 are b[127:64] when in_imm[1]=1, else b[63:0].
- R4: Ops 2 and 3 take the element width from in_size. The result alternates elements of a and b, a first, drawn from a[63:0] and b[63:0] for op 2 and from a[127:64] and b[127:64] for op 3.
- R5: Op 4 sets 16-bit result word 4+k to word 4+in_imm[2k+1:2k] of a and passes a[63:0] unchanged. Op 5 sets word k to word in_imm[2k+1:2k] of a and passes a[127:64] unchanged.
- R6: Op 6 with in_half=0 treats b byte j as the control for result byte j. The result byte is zero when bit 7 of the control is set; otherwise it is byte b[8j+3:8j] of a. Control bits 6:4 have no effect.
- R7: Op 6 with in_half=1 produces 8 result bytes, indexing a with control bits 2:0 only. Bit 7 still clears the byte, and control bits 6:3 have no effect.
- R8: With in_half=1, result bits 127:64 are zero for every operation.
- R9: Op 7 produces an all-zero result.
- R10: A beat accepted on an edge appears with out_valid high after that edge. in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid and out_data stay unchanged.
- R11: During reset, out_valid is 0 and out_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Element size code |
| in_half | input | 1 | 64-bit half-width mode |
| in_imm | input | 8 | Immediate control byte |
| in_a | input | 128 | Operand a |
| in_b | input | 128 | Operand b, or lookup control bytes |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Result vector |

## Verification
On every cycle, the assertions watch the stream rules: an accepted beat leads to a valid output, and a stalled result holds steady. They also check the effect of some requests on the next cycle. A half-width request clears the upper half. The upper-word shuffle keeps the low 64 bits of a. A lookup whose control bytes all have bit 7 set yields zero, and the reserved code yields zero. Lane-by-lane correctness of each shuffle, merge width and lookup index cannot be read from a single property. The bench shows it by comparing each delivered result against its own model, over directed immediates, sizes and control bytes (including junk in the ignored control bits) and a randomised run with consumer stalls.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [2:0] {
    OP_SHUF1   = 3'd0,
    OP_SHUF2   = 3'd1,
    OP_MERGE_L = 3'd2,
    OP_MERGE_H = 3'd3,
    OP_WORD_H  = 3'd4,
    OP_WORD_L  = 3'd5,
    OP_LOOKUP  = 3'd6,
    OP_RSVD    = 3'd7
  } perm_op_e;

  localparam int unsigned SIZE_CODES = 4;

endpackage

// File: rtl/perm_select.sv
module perm_select #(
  parameter int unsigned DW = 128
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [7:0]    imm,
  input  logic [1:0]    size,
  input  logic          half,
  output logic [DW-1:0] one_src,
  output logic [DW-1:0] two_src,
  output logic [DW-1:0] word_hi,
  output logic [DW-1:0] word_lo
);
  localparam int unsigned HW = DW / 2;
  localparam int unsigned QW = DW / 4;
  localparam int unsigned WW = DW / 8;

  logic [QW-1:0] qa [4];
  logic [QW-1:0] qb [4];
  logic [WW-1:0] wa [8];

  for (genvar i = 0; i < 4; i++) begin : g_quarter
    assign qa[i] = a[i*QW +: QW];
    assign qb[i] = b[i*QW +: QW];
  end
  for (genvar i = 0; i < 8; i++) begin : g_word
    assign wa[i] = a[i*WW +: WW];
  end

  logic [HW-1:0] low_perm;
  logic [HW-1:0] high_perm;
  logic [DW-1:0] full_perm;
  logic [DW-1:0] pair_perm;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [1:0] sel;
    assign sel = imm[2*k +: 2];
    assign low_perm[k*WW +: WW]  = wa[sel];
    assign high_perm[k*WW +: WW] = wa[4 + {1'b0, sel}];
    assign full_perm[k*QW +: QW] = qa[sel];
    if (k < 2) begin : g_from_a
      assign pair_perm[k*QW +: QW] = qa[sel];
    end else begin : g_from_b
      assign pair_perm[k*QW +: QW] = qb[sel];
    end
  end

  assign one_src = half ? {{HW{1'b0}}, low_perm} : full_perm;

  always_comb begin
    if (size == 2'd3) begin
      two_src[HW-1:0]  = imm[0] ? a[DW-1:HW] : a[HW-1:0];
      two_src[DW-1:HW] = imm[1] ? b[DW-1:HW] : b[HW-1:0];
    end else begin
      two_src = pair_perm;
    end
  end

  assign word_hi = {high_perm, a[HW-1:0]};
  assign word_lo = {a[DW-1:HW], low_perm};

endmodule

// File: rtl/perm_merge.sv
module perm_merge #(
  parameter int unsigned DW = 128
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    size,
  input  logic          upper,
  output logic [DW-1:0] y
);
  localparam int unsigned HW = DW / 2;

  logic [HW-1:0] src_a;
  logic [HW-1:0] src_b;
  logic [DW-1:0] cand [perm_pkg::SIZE_CODES];

  assign src_a = upper ? a[DW-1:HW] : a[HW-1:0];
  assign src_b = upper ? b[DW-1:HW] : b[HW-1:0];

  for (genvar s = 0; s < int'(perm_pkg::SIZE_CODES); s++) begin : g_size
    localparam int unsigned EW = 8 << s;
    localparam int unsigned NE = HW / EW;
    logic [DW-1:0] vec;
    always_comb begin
      vec = '0;
      for (int i = 0; i < int'(NE); i++) begin
        vec[2*i*EW +: EW]     = src_a[i*EW +: EW];
        vec[(2*i+1)*EW +: EW] = src_b[i*EW +: EW];
      end
    end
    assign cand[s] = vec;
  end

  assign y = cand[size];

endmodule

// File: rtl/perm_lookup.sv
module perm_lookup #(
  parameter int unsigned DW = 128
) (
  input  logic [DW-1:0] table_v,
  input  logic [DW-1:0] ctrl,
  input  logic          half,
  output logic [DW-1:0] y
);
  localparam int unsigned NB   = DW / 8;
  localparam int unsigned IDXW = $clog2(NB);

  logic [7:0] tb [NB];

  for (genvar j = 0; j < int'(NB); j++) begin : g_tab
    assign tb[j] = table_v[8*j +: 8];
  end

  for (genvar j = 0; j < int'(NB); j++) begin : g_byte
    logic [7:0]      c;
    logic [IDXW-1:0] idx;
    logic            unused_bits;
    assign c           = ctrl[8*j +: 8];
    assign idx         = half ? {1'b0, c[IDXW-2:0]} : c[IDXW-1:0];
    assign unused_bits = ^c[6:IDXW];
    assign y[8*j +: 8] = c[7] ? 8'h00 : tb[idx];
  end

endmodule

// File: rtl/perm_unit.sv
module perm_unit #(
  parameter int unsigned DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic          in_half,
  input  logic [7:0]    in_imm,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  import perm_pkg::*;

  localparam int unsigned HW = DW / 2;
  localparam logic [DW-1:0] CLEAR_ALL = {(DW/8){8'h80}};

  perm_op_e      op;
  logic          fire;
  logic [DW-1:0] r_one, r_two, r_whi, r_wlo, r_merge, r_look;
  logic [DW-1:0] pick;
  logic [DW-1:0] result;

  assign op       = perm_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  perm_select #(.DW(DW)) u_select (
    .a       (in_a),
    .b       (in_b),
    .imm     (in_imm),
    .size    (in_size),
    .half    (in_half),
    .one_src (r_one),
    .two_src (r_two),
    .word_hi (r_whi),
    .word_lo (r_wlo)
  );

  perm_merge #(.DW(DW)) u_merge (
    .a     (in_a),
    .b     (in_b),
    .size  (in_size),
    .upper (op == OP_MERGE_H),
    .y     (r_merge)
  );

  perm_lookup #(.DW(DW)) u_lookup (
    .table_v (in_a),
    .ctrl    (in_b),
    .half    (in_half),
    .y       (r_look)
  );

  always_comb begin
    unique case (op)
      OP_SHUF1:               pick = r_one;
      OP_SHUF2:               pick = r_two;
      OP_MERGE_L, OP_MERGE_H: pick = r_merge;
      OP_WORD_H:              pick = r_whi;
      OP_WORD_L:              pick = r_wlo;
      OP_LOOKUP:              pick = r_look;
      default:                pick = '0;
    endcase
  end

  assign result = in_half ? {{HW{1'b0}}, pick[HW-1:0]} : pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ACCEPT_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid) else $error("accept lost"); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) else $error("stall moved"); // R10

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_half) |=> (out_data[DW-1:HW] == '0)) else $error("upper not zero"); // R8

  AST_WORD_H_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_WORD_H) |=> (out_data[HW-1:0] == $past(in_a[HW-1:0]))) else $error("low half altered"); // R5

  AST_LOOKUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_LOOKUP && ((in_b & CLEAR_ALL) == CLEAR_ALL)) |=> (out_data == '0)) else $error("lookup not cleared"); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_RSVD) |=> (out_data == '0)) else $error("reserved not zero"); // R9

endmodule

// File: tb/perm_unit_tb.sv
module perm_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   in_op = '0;
  logic [1:0]   in_size = '0;
  logic         in_half = 1'b0;
  logic [7:0]   in_imm = '0;
  logic [127:0] in_a = '0;
  logic [127:0] in_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  bit stall_mode = 0;

  logic [127:0] exp_q [$];
  string        tag_q [$];
  bit           prev_stall = 0;
  logic [127:0] prev_data = '0;

  always #5 clk = ~clk;

  perm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_half(in_half), .in_imm(in_imm),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] sz,
      input logic hf, input logic [7:0] im, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r, m;
    int sel, ew, base, c, idx, n;
    r = '0;
    case (op)
      3'd0: begin
        ew = hf ? 16 : 32;
        m = (128'd1 << ew) - 128'd1;
        for (int k = 0; k < 4; k++) begin
          sel = (int'(im) >> (2*k)) & 3;
          r |= ((a >> (sel*ew)) & m) << (k*ew);
        end
      end
      3'd1: begin
        if (sz == 2'd3) begin
          r[63:0]   = im[0] ? a[127:64] : a[63:0];
          r[127:64] = im[1] ? b[127:64] : b[63:0];
        end else begin
          m = 128'hFFFF_FFFF;
          for (int k = 0; k < 4; k++) begin
            sel = (int'(im) >> (2*k)) & 3;
            if (k < 2) r |= ((a >> (sel*32)) & m) << (k*32);
            else       r |= ((b >> (sel*32)) & m) << (k*32);
          end
        end
      end
      3'd2, 3'd3: begin
        ew = 8 << sz;
        base = (op == 3'd3) ? 64 : 0;
        m = (128'd1 << ew) - 128'd1;
        for (int i = 0; i < 64/ew; i++) begin
          r |= ((a >> (base + i*ew)) & m) << (2*i*ew);
          r |= ((b >> (base + i*ew)) & m) << ((2*i+1)*ew);
        end
      end
      3'd4: begin
        r[63:0] = a[63:0];
        for (int k = 0; k < 4; k++) begin
          sel = (int'(im) >> (2*k)) & 3;
          r |= ((a >> (64 + sel*16)) & 128'hFFFF) << (64 + k*16);
        end
      end
      3'd5: begin
        r[127:64] = a[127:64];
        for (int k = 0; k < 4; k++) begin
          sel = (int'(im) >> (2*k)) & 3;
          r |= ((a >> (sel*16)) & 128'hFFFF) << (k*16);
        end
      end
      3'd6: begin
        n = hf ? 8 : 16;
        for (int j = 0; j < n; j++) begin
          c = int'((b >> (8*j)) & 128'hFF);
          if (c < 128) begin
            idx = hf ? (c & 7) : (c & 15);
            r |= ((a >> (8*idx)) & 128'hFF) << (8*j);
          end
        end
      end
      default: r = '0;
    endcase
    if (hf) r[127:64] = '0;
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [1:0] sz, input logic hf);
    case (op)
      3'd0: return "R1";
      3'd1: return hf ? "R8" : ((sz == 2'd3) ? "R3" : "R2");
      3'd2, 3'd3: return hf ? "R8" : "R4";
      3'd4, 3'd5: return hf ? "R8" : "R5";
      3'd6: return hf ? "R7" : "R6";
      default: return "R9";
    endcase
  endfunction

  // scoreboard: compare delivered beats, check stalls, record accepted beats
  always @(negedge clk) begin
    if (!rst_n) begin
      compared += 2;
      if (out_valid !== 1'b0) begin
        mismatched++; $display("FAIL R11 out_valid act=%b exp=0", out_valid);
      end
      if (out_data !== '0) begin
        mismatched++; $display("FAIL R11 out_data act=%h exp=0", out_data);
      end
    end else begin
      if (prev_stall) begin
        compared++;
        if (out_valid !== 1'b1 || out_data !== prev_data) begin
          mismatched++;
          $display("FAIL R10 stall hold act=%b/%h exp=1/%h", out_valid, out_data, prev_data);
        end
      end
      compared++;
      if (in_ready !== (!out_valid || out_ready)) begin
        mismatched++;
        $display("FAIL R10 in_ready act=%b exp=%b", in_ready, (!out_valid || out_ready));
      end
      if (out_valid && out_ready) begin
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++; $display("FAIL R10 unexpected beat act=%h exp=none", out_data);
        end else begin
          logic [127:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_data !== e) begin
            mismatched++; $display("FAIL %s act=%h exp=%h", t, out_data, e);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_op, in_size, in_half, in_imm, in_a, in_b));
        tag_q.push_back(tag_of(in_op, in_size, in_half));
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      mismatched++;
      $display("FAIL watchdog act=%0d exp<50000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic send(input logic [2:0] op, input logic [1:0] sz, input logic hf,
                      input logic [7:0] im, input logic [127:0] va, input logic [127:0] vb);
    bit acc;
    in_valid = 1'b1; in_op = op; in_size = sz; in_half = hf;
    in_imm = im; in_a = va; in_b = vb;
    do begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  localparam logic [127:0] VA = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
  localparam logic [127:0] VB = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 one-source shuffle: identity, broadcast, reverse, half width
    send(3'd0, 2'd2, 1'b0, 8'hE4, VA, VB);
    send(3'd0, 2'd2, 1'b0, 8'h00, VA, VB);
    send(3'd0, 2'd2, 1'b0, 8'h1B, VA, VB);
    send(3'd0, 2'd1, 1'b1, 8'h1B, VA, VB);
    // R2 / R3 two-source select
    send(3'd1, 2'd2, 1'b0, 8'hB1, VA, VB);
    for (int i = 0; i < 4; i++) send(3'd1, 2'd3, 1'b0, 8'(i), VA, VB);
    // R4 merges at every size, both halves
    for (int s = 0; s < 4; s++) begin
      send(3'd2, 2'(s), 1'b0, 8'h00, VA, VB);
      send(3'd3, 2'(s), 1'b0, 8'h00, VA, VB);
    end
    // R5 word shuffles
    send(3'd4, 2'd1, 1'b0, 8'h1B, VA, VB);
    send(3'd5, 2'd1, 1'b0, 8'h4E, VA, VB);
    // R6 lookup, ignored bits 6:4 set, all-clear control
    send(3'd6, 2'd0, 1'b0, 8'h00, VA, 128'h000102030405060708090A0B0C0D0E0F);
    send(3'd6, 2'd0, 1'b0, 8'h00, VA, 128'h707172737475767778797A7B7C7D7E7F);
    send(3'd6, 2'd0, 1'b0, 8'h00, VA, 128'h80FF_0F8F_7081_0001_8000_FFFF_0203_F00F);
    send(3'd6, 2'd0, 1'b0, 8'h00, VA, {16{8'h80}});
    // R7 lookup half width, bits 6:3 ignored
    send(3'd6, 2'd0, 1'b1, 8'h00, VA, 128'h0F0E0D0C0B0A0908_7F780F8001020304);
    // R8 half mode across ops, R9 reserved
    send(3'd1, 2'd3, 1'b1, 8'h03, VA, VB);
    send(3'd2, 2'd0, 1'b1, 8'h00, VA, VB);
    send(3'd4, 2'd1, 1'b1, 8'hFF, VA, VB);
    send(3'd7, 2'd0, 1'b0, 8'hFF, VA, VB);
    // R10 randomised run with consumer stalls
    stall_mode = 1;
    for (int i = 0; i < 400; i++)
      send(3'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), rnd128(), rnd128());
    stall_mode = 0;
    repeat (10) @(posedge clk);
    #1;
    compared++;
    if (exp_q.size() != 0) begin
      mismatched++; $display("FAIL R10 undelivered act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule